// File: doc/BRIEF.md
# Register-Dependency Pipeline Interlock Unit

This unit sits between instruction decode and the first of two execute stages (E1, E2) of an integer pipeline. Each cycle it looks at one decoded data-processing instruction waiting at the entry of E1. It compares the registers that instruction reads with the destinations of the two older instructions still in E1 and E2. It then either lets the instruction issue, with a forwarding path chosen for every operand, or holds it for a cycle.

The rules follow from the stage in which each operand is consumed and the stage in which each result appears. Both depend on the instruction class and on the second-operand form. A shifted second operand and a shift amount are consumed in E1. The first operand, an unshifted register operand and the old destination value are consumed in E2. An ALU result appears at the end of E2. A move result appears at the end of E1 if the move is unconditional, otherwise at the end of E2. The rotate-with-extend form always loses one cycle. Apart from stalls the unit issues one instruction per cycle.

The pipeline behind the unit always advances. A stall sends a bubble into E1.

Top module: `reg_interlock`

## Requirements
- R1: Class encodings are 0 = ALU (writes a result), 1 = TEST (compare, no result) and 2 = MOVE. Operand-form encodings are 0 = IMM, 1 = REG (plain register), 2 = SIMM (register shifted by a constant), 3 = RRX and 4 = SREG (register shifted by a register). For ALU and TEST, Rn is consumed in E2. Rm is consumed in E2 for REG and in E1 for SIMM, RRX and SREG. Rs is consumed in E1 for SREG. ALU also consumes the old Rd in E2.
- R2: For MOVE, Rn is unused. Rm is consumed in E1 for every register form. Rs is consumed in E1 for SREG. The old Rd is consumed in E2.
- R3: An ALU result is ready at the end of E2. An unconditional MOVE result is ready at the end of E1, and a conditional MOVE result at the end of E2.
- R4: An E1 operand that matches the destination of the instruction issued in the previous cycle stalls if that result is ready only at the end of E2. The stall lasts exactly one cycle. E2 operands never stall.
- R5: Forwarding codes are 0 = register file, 1 = E1-result path and 2 = E2-result path. The newest matching producer wins. An E2 operand matching the previous instruction uses path 2. An E1 operand uses path 1 for the previous instruction and path 2 for the instruction issued two cycles earlier. All codes read 0 in a cycle without issue.
- R6: An RRX instruction never issues in the first cycle it is presented. When a dependency stall is also present, the two stalls overlap.
- R7: TEST instructions, and ALU or MOVE instructions whose Rd is 15, enter no tracker entry, so no later operand matches them. `pc_dest` is high while such a register-15 writer is presented.
- R8: When no stall applies, `issue` equals `in_valid`, which gives one instruction per cycle.
- R9: After reset the tracker is empty, `stall` and `issue` are low with no valid input, and all forwarding codes are 0.
- R10: Register fields that a form does not use never cause a stall or a forwarding code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented for E1 |
| in_class | input | 2 | Instruction class |
| in_shift | input | 3 | Second-operand form |
| in_cond | input | 1 | Instruction is conditional |
| in_rn | input | RW | First operand register |
| in_rm | input | RW | Second operand register |
| in_rs | input | RW | Shift amount register |
| in_rd | input | RW | Destination register |
| stall | output | 1 | Hold the presented instruction this cycle |
| issue | output | 1 | Presented instruction enters E1 at the next edge |
| pc_dest | output | 1 | Presented instruction writes register 15 |
| rn_fwd | output | 2 | Forwarding code for Rn |
| rm_fwd | output | 2 | Forwarding code for Rm |
| rs_fwd | output | 2 | Forwarding code for Rs |
| rd_fwd | output | 2 | Forwarding code for the old Rd |

## Verification
The assertions assume several things about the inputs. Class 3 and operand forms above 4 never appear. A stalled instruction is held unchanged until it issues. An instruction issued in the last cycle is not presented again. The stimulus builds each instruction from the legal encodings and keeps its inputs fixed through every stall. It drops `in_valid` between scenarios so that each dependency pair starts from an empty tracker, except where the test needs a producer two cycles back.

// File: rtl/reg_interlock.sv
module reg_interlock #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_class,
  input  logic [2:0]    in_shift,
  input  logic          in_cond,
  input  logic [RW-1:0] in_rn,
  input  logic [RW-1:0] in_rm,
  input  logic [RW-1:0] in_rs,
  input  logic [RW-1:0] in_rd,
  output logic          stall,
  output logic          issue,
  output logic          pc_dest,
  output logic [1:0]    rn_fwd,
  output logic [1:0]    rm_fwd,
  output logic [1:0]    rs_fwd,
  output logic [1:0]    rd_fwd
);
  localparam logic [RW-1:0] PC_IDX = {RW{1'b1}};
  localparam logic [1:0] C_ALU = 2'd0, C_TST = 2'd1, C_MOV = 2'd2;
  localparam logic [2:0] S_IMM = 3'd0, S_REG = 3'd1, S_RRX = 3'd3, S_SREG = 3'd4;
  localparam logic [1:0] F_RF = 2'd0, F_E1 = 2'd1, F_E2 = 2'd2;

  logic          e1_v, e1_early, e2_v, rrx_seen;
  logic [RW-1:0] e1_rd, e2_rd;

  logic is_alu, is_tst, is_mov, reg_op2, shifted;
  assign is_alu  = in_class == C_ALU;
  assign is_tst  = in_class == C_TST;
  assign is_mov  = in_class == C_MOV;
  assign reg_op2 = in_shift != S_IMM;
  assign shifted = reg_op2 && in_shift != S_REG;

  logic use_rn, use_rm_e1, use_rm_e2, use_rs, use_rd;
  assign use_rn    = is_alu || is_tst;
  assign use_rm_e1 = reg_op2 && (is_mov || shifted);
  assign use_rm_e2 = (is_alu || is_tst) && in_shift == S_REG;
  assign use_rs    = (is_alu || is_tst || is_mov) && in_shift == S_SREG;
  assign use_rd    = is_alu || is_mov;

  logic writes, early;
  assign pc_dest = in_valid && (is_alu || is_mov) && in_rd == PC_IDX;
  assign writes  = (is_alu || is_mov) && in_rd != PC_IDX;
  assign early   = is_mov && !in_cond;

  function automatic logic late_hit(input logic u, input logic [RW-1:0] r,
                                    input logic v, input logic [RW-1:0] d, input logic e);
    return u && v && d == r && !e;
  endfunction

  logic dep_stall, rrx_wait;
  assign dep_stall = late_hit(use_rm_e1, in_rm, e1_v, e1_rd, e1_early) ||
                     late_hit(use_rs, in_rs, e1_v, e1_rd, e1_early);
  assign rrx_wait  = in_shift == S_RRX && !rrx_seen;
  assign stall     = in_valid && (dep_stall || rrx_wait);
  assign issue     = in_valid && !stall;

  function automatic logic [1:0] fwd_e1(input logic go, input logic [RW-1:0] r,
                                        input logic v1, input logic [RW-1:0] d1,
                                        input logic v2, input logic [RW-1:0] d2);
    if (!go) return F_RF;
    if (v1 && d1 == r) return F_E1;
    if (v2 && d2 == r) return F_E2;
    return F_RF;
  endfunction

  function automatic logic [1:0] fwd_e2(input logic go, input logic [RW-1:0] r,
                                        input logic v1, input logic [RW-1:0] d1);
    return (go && v1 && d1 == r) ? F_E2 : F_RF;
  endfunction

  assign rm_fwd = use_rm_e1 ? fwd_e1(issue, in_rm, e1_v, e1_rd, e2_v, e2_rd)
                            : fwd_e2(issue && use_rm_e2, in_rm, e1_v, e1_rd);
  assign rs_fwd = fwd_e1(issue && use_rs, in_rs, e1_v, e1_rd, e2_v, e2_rd);
  assign rn_fwd = fwd_e2(issue && use_rn, in_rn, e1_v, e1_rd);
  assign rd_fwd = fwd_e2(issue && use_rd, in_rd, e1_v, e1_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1_v <= 1'b0; e1_early <= 1'b0; e1_rd <= '0;
      e2_v <= 1'b0; e2_rd <= '0;
      rrx_seen <= 1'b0;
    end else begin
      e2_v     <= e1_v;
      e2_rd    <= e1_rd;
      e1_v     <= issue && writes;
      e1_rd    <= in_rd;
      e1_early <= early;
      rrx_seen <= in_valid && in_shift == S_RRX && !issue;
    end
  end
endmodule

module reg_interlock_chk #(
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_class,
  input logic [2:0]    in_shift,
  input logic          in_cond,
  input logic [RW-1:0] in_rn,
  input logic [RW-1:0] in_rm,
  input logic [RW-1:0] in_rs,
  input logic [RW-1:0] in_rd,
  input logic          stall,
  input logic          issue,
  input logic          pc_dest,
  input logic [1:0]    rn_fwd,
  input logic [1:0]    rm_fwd,
  input logic [1:0]    rs_fwd,
  input logic [1:0]    rd_fwd
);
  logic          m_late, m_early, m_any;
  logic [RW-1:0] m_rd;
  logic          e1_rm, e1_rs, hz;
  assign e1_rm = in_shift != 3'd0 && (in_class == 2'd2 || in_shift != 3'd1);
  assign e1_rs = in_shift == 3'd4;
  assign hz    = m_late && ((e1_rm && in_rm == m_rd) || (e1_rs && in_rs == m_rd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_late <= 1'b0; m_early <= 1'b0; m_any <= 1'b0; m_rd <= '0;
    end else begin
      m_any   <= issue && in_class != 2'd1 && in_rd != {RW{1'b1}};
      m_late  <= issue && in_rd != {RW{1'b1}} &&
                 (in_class == 2'd0 || (in_class == 2'd2 && in_cond));
      m_early <= issue && in_rd != {RW{1'b1}} && in_class == 2'd2 && !in_cond;
      m_rd    <= in_rd;
    end
  end

  AST_LEGAL_INPUT:  assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_class != 2'd3 && in_shift <= 3'd4);                       // R1
  AST_LATE_STALL:   assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_shift != 3'd3 |-> issue == !hz);                            // R4
  AST_RRX_HELD:     assert property (@(posedge clk) disable iff (!rst_n)
    issue && in_shift == 3'd3 |-> $past(in_valid) && $past(stall));            // R6
  AST_EARLY_PATH:   assert property (@(posedge clk) disable iff (!rst_n)
    issue && rm_fwd == 2'd1 |-> m_early && m_rd == in_rm);                     // R5
  AST_NO_ENTRY:     assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !m_any && in_shift != 3'd3 |-> !stall);                        // R7
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !stall && !issue && rm_fwd == 2'd0 && rn_fwd == 2'd0);       // R9
endmodule

bind reg_interlock reg_interlock_chk #(.RW(RW)) u_chk (.*);

// File: tb/test_reg_interlock.sv
`timescale 1ns/1ps
module test_reg_interlock;
  localparam int RW = 4;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_cond = 0;
  logic [1:0] in_class = 0;
  logic [2:0] in_shift = 0;
  logic [RW-1:0] in_rn = 0, in_rm = 0, in_rs = 0, in_rd = 0;
  logic stall, issue, pc_dest;
  logic [1:0] rn_fwd, rm_fwd, rs_fwd, rd_fwd;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reg_interlock #(.RW(RW)) i_reg_interlock (.*);

  localparam logic [1:0] ALU = 0, TST = 1, MOV = 2;
  localparam logic [2:0] IMM = 0, REG = 1, SIMM = 2, RRX = 3, SREG = 4;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int st;
  logic [1:0] fn, fm, fs, fd;
  logic pcf;

  task automatic run(input logic [1:0] c, input logic [2:0] s, input int n, m, q, d,
                     input bit cnd);
    @(negedge clk);
    in_valid = 1; in_class = c; in_shift = s; in_cond = cnd;
    in_rn = n[RW-1:0]; in_rm = m[RW-1:0]; in_rs = q[RW-1:0]; in_rd = d[RW-1:0];
    st = 0;
    for (int k = 0; k < 8; k++) begin
      #1;
      pcf = pc_dest;
      if (issue) begin
        fn = rn_fwd; fm = rm_fwd; fs = rs_fwd; fd = rd_fwd;
        break;
      end
      st++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R9 stall during reset", stall, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R9 stall idle", stall, 0);
    chk("R9 issue idle", issue, 0);
    chk("R9 rm_fwd idle", rm_fwd, 0);
    run(ALU, SIMM, 1, 2, 0, 3, 0);
    chk("R9 empty tracker no stall", st, 0);
    chk("R9 empty tracker rm_fwd", fm, 0);
    idle(2);
  endtask

  task automatic t_alu_shifted;
    run(ALU, IMM, 0, 0, 0, 3, 0);
    run(ALU, SIMM, 1, 3, 0, 4, 0);
    chk("R4 ALU->SIMM stall", st, 1);
    chk("R5 ALU->SIMM rm_fwd", fm, 2);
    idle(2);
  endtask

  task automatic t_alu_plain;
    run(ALU, IMM, 0, 0, 0, 3, 0);
    run(ALU, REG, 3, 3, 0, 5, 0);
    chk("R1 ALU->REG no stall", st, 0);
    chk("R5 ALU->REG rm_fwd", fm, 2);
    chk("R5 ALU->REG rn_fwd", fn, 2);
    idle(2);
  endtask

  task automatic t_shift_reg;
    run(ALU, IMM, 0, 0, 0, 5, 0);
    run(TST, SREG, 1, 2, 5, 0, 0);
    chk("R1 Rs in E1 stall", st, 1);
    chk("R5 Rs fwd", fs, 2);
    idle(2);
  endtask

  task automatic t_mov_uncond;
    run(MOV, IMM, 0, 0, 0, 6, 0);
    run(ALU, SIMM, 0, 6, 0, 1, 0);
    chk("R3 uncond MOVE no stall", st, 0);
    chk("R5 uncond MOVE early path", fm, 1);
    idle(2);
  endtask

  task automatic t_mov_cond;
    run(MOV, IMM, 0, 0, 0, 7, 1);
    run(MOV, SIMM, 0, 7, 0, 1, 0);
    chk("R3 cond MOVE stall", st, 1);
    chk("R5 cond MOVE late path", fm, 2);
    idle(2);
  endtask

  task automatic t_no_entry;
    run(TST, IMM, 8, 0, 0, 8, 0);
    run(ALU, SIMM, 8, 8, 0, 2, 0);
    chk("R7 TEST no stall", st, 0);
    chk("R7 TEST no fwd", fm, 0);
    idle(2);
    run(ALU, IMM, 0, 0, 0, 15, 0);
    chk("R7 pc_dest flagged", pcf, 1);
    run(ALU, SIMM, 15, 15, 0, 2, 0);
    chk("R7 PC no stall", st, 0);
    chk("R7 PC no fwd", fm, 0);
    chk("R7 pc_dest low", pcf, 0);
    idle(2);
  endtask

  task automatic t_rrx;
    run(ALU, RRX, 1, 2, 0, 4, 0);
    chk("R6 RRX stall alone", st, 1);
    idle(2);
    run(ALU, IMM, 0, 0, 0, 9, 0);
    run(ALU, RRX, 0, 9, 0, 4, 0);
    chk("R6 RRX with dependency overlap", st, 1);
    chk("R6 RRX rm_fwd", fm, 2);
    idle(2);
  endtask

  task automatic t_two_back;
    run(ALU, IMM, 0, 0, 0, 9, 0);
    run(ALU, IMM, 0, 0, 0, 10, 0);
    run(ALU, SIMM, 0, 9, 0, 11, 0);
    chk("R8 two back no stall", st, 0);
    chk("R5 two back E2 path", fm, 2);
    idle(2);
  endtask

  task automatic t_priority;
    run(ALU, IMM, 0, 0, 0, 2, 0);
    run(MOV, IMM, 0, 0, 0, 2, 0);
    run(ALU, SIMM, 0, 2, 0, 3, 0);
    chk("R5 newest early wins no stall", st, 0);
    chk("R5 newest early wins fwd", fm, 1);
    idle(2);
    run(MOV, IMM, 0, 0, 0, 2, 0);
    run(ALU, IMM, 0, 0, 0, 2, 0);
    run(ALU, SIMM, 0, 2, 0, 3, 0);
    chk("R4 newest late wins stall", st, 1);
    chk("R5 newest late wins fwd", fm, 2);
    idle(2);
  endtask

  task automatic t_ignored;
    run(ALU, IMM, 0, 0, 0, 11, 0);
    run(ALU, IMM, 0, 11, 11, 1, 0);
    chk("R10 unused rm/rs no stall", st, 0);
    chk("R10 unused rm fwd", fm, 0);
    chk("R10 unused rs fwd", fs, 0);
    idle(2);
    run(ALU, IMM, 0, 0, 0, 12, 0);
    run(MOV, SIMM, 12, 1, 0, 4, 0);
    chk("R2 MOVE ignores Rn", fn, 0);
    chk("R2 MOVE ignores Rn stall", st, 0);
    idle(2);
    run(ALU, IMM, 0, 0, 0, 12, 0);
    run(MOV, REG, 0, 12, 0, 4, 0);
    chk("R2 MOVE REG Rm in E1 stall", st, 1);
    idle(2);
  endtask

  task automatic t_old_rd;
    run(ALU, IMM, 0, 0, 0, 13, 0);
    run(MOV, IMM, 0, 0, 0, 13, 1);
    chk("R2 old Rd no stall", st, 0);
    chk("R2 old Rd fwd", fd, 2);
    idle(2);
  endtask

  task automatic t_stream;
    int tot = 0;
    for (int k = 1; k <= 4; k++) begin
      run(ALU, REG, k, k + 4, 0, k, 0);
      tot += st;
    end
    chk("R8 independent stream stalls", tot, 0);
    idle(2);
  endtask

  initial begin
    t_reset;
    t_alu_shifted;
    t_alu_plain;
    t_shift_reg;
    t_mov_uncond;
    t_mov_cond;
    t_no_entry;
    t_rrx;
    t_two_back;
    t_priority;
    t_ignored;
    t_old_rd;
    t_stream;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule